// File: doc/BRIEF.md
# CAN Bus-Off Recovery Sequencer

This block watches the transmit and receive error counters of a CAN node, reports its fault-confinement condition (warning, passive, bus off) and runs the recovery from bus off. When the transmit counter goes past 255, the block raises its own init flag. That flag halts all bus traffic. The block then waits for software to clear init. After that it watches the sampled bus bits for 129 stretches of 11 consecutive recessive bits. When the last stretch completes, it asks the external counter logic to zero both error counters and returns the node to normal operation.

While recovery runs, every completed recessive stretch posts a bit0 status code (value 5) for the last-error field. The receive-counter view that software reads shows the number of stretches seen so far. This lets software tell whether the bus is stuck dominant or keeps being disturbed.

The bus bits arrive as a valid-qualified stream. There is no ready signal, because the block takes one bit on every cycle in which `bit_vld_i` is high and it can never apply back-pressure. A cycle with `bit_vld_i` low carries no bit and does not break a recessive run. Counter bookkeeping and bit timing sit outside this block.

Top module: `fc_recovery_seq`

## Requirements
- R1: After reset, `init_o` is 1, `bus_off_o` is 0, `act_o` is 1 (idle), and `lec_wr_o`, `lec_code_o` and `cnt_clr_o` are 0.
- R2: In normal operation, a `tec_i` value of 256 or more at a clock edge makes `bus_off_o` and `init_o` 1 after that edge, and sets `act_o` to 0 (synchronizing).
- R3: While bus off and waiting for software, `init_set_i` and the bit stream have no effect. A one-cycle `init_clr_i` clears `init_o` and starts recovery with the sequence count at 0.
- R4: During recovery, `init_set_i` and `init_clr_i` are ignored. `init_o` stays 0, the sequence count is kept, and recovery is not shortened.
- R5: During recovery, the edge that takes the 11th consecutive recessive valid bit (`bit_rx_i`=1) is followed by one cycle with `lec_wr_o`=1 and `lec_code_o`=5.
- R6: A valid dominant bit (`bit_rx_i`=0) resets the recessive run to zero and leaves the sequence count unchanged. Cycles with `bit_vld_i`=0 neither extend nor break a run.
- R7: While bus off, `rec_view_o` shows the low 7 bits of the completed-sequence count. Otherwise it shows `rec_i[6:0]`.
- R8: The edge that completes the 129th sequence is followed by one cycle in which `cnt_clr_o`=1 and `lec_wr_o`=1 together. From that cycle on, `bus_off_o`=0, `act_o`=1 and `init_o`=0.
- R9: `err_warn_o` is 1 exactly when `tec_i` or `rec_i` is 96 or more.
- R10: `err_pass_o` is 1 exactly when `tec_i` or `rec_i` is 128 or more.
- R11: In normal operation, `init_set_i` sets `init_o` and `init_clr_i` clears it at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tec_i | input | 9 | Transmit error counter |
| rec_i | input | 8 | Receive error counter |
| init_set_i | input | 1 | Software request to set init |
| init_clr_i | input | 1 | Software request to clear init |
| bit_vld_i | input | 1 | Bus bit sample valid |
| bit_rx_i | input | 1 | Sampled bus level, 1 = recessive |
| init_o | output | 1 | Init flag; bus activity halted while 1 |
| bus_off_o | output | 1 | Node is bus off |
| err_warn_o | output | 1 | Error warning status |
| err_pass_o | output | 1 | Error passive status |
| act_o | output | 2 | Activity: 0 synchronizing, 1 idle |
| lec_wr_o | output | 1 | One-cycle write strobe for the last-error field |
| lec_code_o | output | 3 | Code to write (5 = bit0) |
| cnt_clr_o | output | 1 | One-cycle request to zero both error counters |
| rec_view_o | output | 7 | Receive-counter field as seen by software |

## Verification
Two events can fall into the same cycle. One is the bit0 status post for a completed recessive stretch; the other is the end-of-recovery counter clear. They coincide on the 129th stretch. The bench runs a full recovery, with dominant bits, idle gaps and ignored init writes mixed in. It checks that both strobes rise together exactly once, in the cycle after the final bit. It also checks that the 128th stretch posts the status code alone, without the clear.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {
    FC_NORMAL  = 2'd0,
    FC_HOLD    = 2'd1,
    FC_RECOVER = 2'd2
  } fc_state_t;

  localparam logic [1:0] ACT_SYNC = 2'd0;
  localparam logic [1:0] ACT_IDLE = 2'd1;
  localparam logic [2:0] LEC_BIT0 = 3'd5;
endpackage

// File: rtl/fc_run_counter.sv
module fc_run_counter #(
  parameter int RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic vld_i,
  input  logic rx_i,
  output logic done_o
);
  localparam int RW = $clog2(RUN_LEN);
  localparam logic [RW-1:0] LAST = RW'(RUN_LEN - 1);

  logic [RW-1:0] run_q;

  assign done_o = en_i && vld_i && rx_i && (run_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               run_q <= '0;
    else if (!en_i)           run_q <= '0;
    else if (vld_i && !rx_i)  run_q <= '0;
    else if (done_o)          run_q <= '0;
    else if (vld_i && rx_i)   run_q <= run_q + 1'b1;
  end

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= LAST);  // R6
  AST_DOMINANT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && vld_i && !rx_i) |=> (run_q == '0));  // R6
endmodule

// File: rtl/fc_seq_counter.sv
module fc_seq_counter #(
  parameter int SEQ_TARGET = 129
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic inc_i,
  output logic last_o,
  output logic [$clog2(SEQ_TARGET+1)-1:0] cnt_o
);
  localparam int SW = $clog2(SEQ_TARGET + 1);
  localparam logic [SW-1:0] FINAL = SW'(SEQ_TARGET - 1);

  logic [SW-1:0] cnt_q;

  assign last_o = en_i && inc_i && (cnt_q == FINAL);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (last_o)      cnt_q <= '0;
    else if (inc_i)       cnt_q <= cnt_q + 1'b1;
  end

  AST_SEQ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FINAL);  // R8
  AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !inc_i) |=> $stable(cnt_q));  // R6
endmodule

// File: rtl/fc_state_ctrl.sv
module fc_state_ctrl
  import fc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      over_i,
  input  logic      guard_i,
  input  logic      init_set_i,
  input  logic      init_clr_i,
  input  logic      last_i,
  output fc_state_t state_o,
  output logic      init_o
);
  fc_state_t state_q, state_d;
  logic      init_q, init_d;

  always_comb begin
    state_d = state_q;
    init_d  = init_q;
    unique case (state_q)
      FC_NORMAL: begin
        if (over_i && !guard_i) begin
          state_d = FC_HOLD;
          init_d  = 1'b1;
        end else if (init_set_i) begin
          init_d = 1'b1;
        end else if (init_clr_i) begin
          init_d = 1'b0;
        end
      end
      FC_HOLD: begin
        if (init_clr_i) begin
          state_d = FC_RECOVER;
          init_d  = 1'b0;
        end
      end
      FC_RECOVER: begin
        init_d = 1'b0;
        if (last_i) state_d = FC_NORMAL;
      end
      default: begin
        state_d = FC_NORMAL;
        init_d  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FC_NORMAL;
      init_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      init_q  <= init_d;
    end
  end

  assign state_o = state_q;
  assign init_o  = init_q;

  AST_HOLD_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FC_HOLD) |-> init_q);  // R2
  AST_NO_SHORTCUT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FC_RECOVER && !last_i) |=> (state_q == FC_RECOVER));  // R4
  AST_RECOVER_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FC_RECOVER) |=> !init_q);  // R4
endmodule

// File: rtl/fc_recovery_seq.sv
module fc_recovery_seq
  import fc_pkg::*;
#(
  parameter int TEC_W      = 9,
  parameter int REC_W      = 8,
  parameter int VIEW_W     = 7,
  parameter int RUN_LEN    = 11,
  parameter int SEQ_TARGET = 129,
  parameter int WARN_LIM   = 96,
  parameter int PASS_LIM   = 128,
  parameter int BOFF_LIM   = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEC_W-1:0]  tec_i,
  input  logic [REC_W-1:0]  rec_i,
  input  logic              init_set_i,
  input  logic              init_clr_i,
  input  logic              bit_vld_i,
  input  logic              bit_rx_i,
  output logic              init_o,
  output logic              bus_off_o,
  output logic              err_warn_o,
  output logic              err_pass_o,
  output logic [1:0]        act_o,
  output logic              lec_wr_o,
  output logic [2:0]        lec_code_o,
  output logic              cnt_clr_o,
  output logic [VIEW_W-1:0] rec_view_o
);
  localparam int SW = $clog2(SEQ_TARGET + 1);

  fc_state_t      state;
  logic           recovering, run_done, seq_last;
  logic [SW-1:0]  seq_cnt;
  logic           over;

  assign over       = tec_i >= TEC_W'(BOFF_LIM);
  assign recovering = (state == FC_RECOVER);

  fc_state_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .over_i     (over),
    .guard_i    (cnt_clr_o),
    .init_set_i (init_set_i),
    .init_clr_i (init_clr_i),
    .last_i     (seq_last),
    .state_o    (state),
    .init_o     (init_o)
  );

  fc_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (recovering),
    .vld_i  (bit_vld_i),
    .rx_i   (bit_rx_i),
    .done_o (run_done)
  );

  fc_seq_counter #(.SEQ_TARGET(SEQ_TARGET)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (recovering),
    .inc_i  (run_done),
    .last_o (seq_last),
    .cnt_o  (seq_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lec_wr_o   <= 1'b0;
      lec_code_o <= 3'd0;
      cnt_clr_o  <= 1'b0;
    end else begin
      lec_wr_o   <= run_done;
      lec_code_o <= run_done ? LEC_BIT0 : 3'd0;
      cnt_clr_o  <= seq_last;
    end
  end

  assign bus_off_o  = (state != FC_NORMAL);
  assign act_o      = bus_off_o ? ACT_SYNC : ACT_IDLE;
  assign err_warn_o = (tec_i >= TEC_W'(WARN_LIM)) || (rec_i >= REC_W'(WARN_LIM));
  assign err_pass_o = (tec_i >= TEC_W'(PASS_LIM)) || (rec_i >= REC_W'(PASS_LIM));
  assign rec_view_o = bus_off_o ? seq_cnt[VIEW_W-1:0] : rec_i[VIEW_W-1:0];

  AST_ENTRY_SETS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_off_o) |-> init_o);  // R2
  AST_CLEAR_WITH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr_o |-> (lec_wr_o && !bus_off_o));  // R8
  AST_CODE_IS_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    lec_wr_o |-> (lec_code_o == LEC_BIT0));  // R5
  AST_CODE_ONLY_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    lec_wr_o |-> $past(recovering));  // R5
  AST_PASSIVE_IMPLIES_WARN: assert property (@(posedge clk) disable iff (!rst_n)
    err_pass_o |-> err_warn_o);  // R10
endmodule

// File: tb/fc_recovery_seq_tb_top.sv
module fc_recovery_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] tec_i = '0;
  logic [7:0] rec_i = '0;
  logic       init_set_i = 1'b0, init_clr_i = 1'b0;
  logic       bit_vld_i = 1'b0, bit_rx_i = 1'b1;
  logic       init_o, bus_off_o, err_warn_o, err_pass_o;
  logic [1:0] act_o;
  logic       lec_wr_o, cnt_clr_o;
  logic [2:0] lec_code_o;
  logic [6:0] rec_view_o;

  int checks = 0;
  int errors = 0;
  int lec_pulses;
  int clr_pulses;

  always #2 clk = ~clk;

  fc_recovery_seq dut_i (
    .clk(clk), .rst_n(rst_n), .tec_i(tec_i), .rec_i(rec_i),
    .init_set_i(init_set_i), .init_clr_i(init_clr_i),
    .bit_vld_i(bit_vld_i), .bit_rx_i(bit_rx_i),
    .init_o(init_o), .bus_off_o(bus_off_o), .err_warn_o(err_warn_o),
    .err_pass_o(err_pass_o), .act_o(act_o), .lec_wr_o(lec_wr_o),
    .lec_code_o(lec_code_o), .cnt_clr_o(cnt_clr_o), .rec_view_o(rec_view_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_bit(input logic rx);
    bit_vld_i = 1'b1;
    bit_rx_i  = rx;
    step();
    bit_vld_i = 1'b0;
    bit_rx_i  = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 init", int'(init_o), 1);
    chk("R1 bus_off", int'(bus_off_o), 0);
    chk("R1 act", int'(act_o), 1);
    chk("R1 pulses", int'({lec_wr_o, lec_code_o, cnt_clr_o}), 0);
  endtask

  task automatic t_flags();
    tec_i = 9'd95;  rec_i = 8'd95;  #1;
    chk("R9 both 95", int'(err_warn_o), 0);
    rec_i = 8'd96; #1;
    chk("R9 rec 96", int'(err_warn_o), 1);
    chk("R10 rec 96", int'(err_pass_o), 0);
    rec_i = 8'd0; tec_i = 9'd127; #1;
    chk("R10 tec 127", int'(err_pass_o), 0);
    tec_i = 9'd128; #1;
    chk("R10 tec 128", int'(err_pass_o), 1);
    rec_i = 8'h25; #1;
    chk("R7 view normal", int'(rec_view_o), 'h25);
    tec_i = 9'd0; rec_i = 8'd0;
    step();
  endtask

  task automatic t_init_normal();
    init_clr_i = 1'b1; step(); init_clr_i = 1'b0;
    chk("R11 clear", int'(init_o), 0);
    init_set_i = 1'b1; step(); init_set_i = 1'b0;
    chk("R11 set", int'(init_o), 1);
    init_clr_i = 1'b1; step(); init_clr_i = 1'b0;
    chk("R11 clear again", int'(init_o), 0);
    send_bit(1'b1);
    chk("R11 bits ignored normal", int'(lec_wr_o), 0);
  endtask

  task automatic t_enter();
    tec_i = 9'd255; step();
    chk("R2 255 stays", int'(bus_off_o), 0);
    tec_i = 9'd300; step();
    chk("R2 bus_off", int'(bus_off_o), 1);
    chk("R2 init", int'(init_o), 1);
    chk("R2 act sync", int'(act_o), 0);
  endtask

  task automatic t_hold();
    lec_pulses = 0;
    init_set_i = 1'b1; step(); init_set_i = 1'b0;
    for (int i = 0; i < 12; i++) begin
      send_bit(1'b1);
      lec_pulses += int'(lec_wr_o);
    end
    chk("R3 no codes in hold", lec_pulses, 0);
    chk("R3 still init", int'(init_o), 1);
    chk("R3 view zero", int'(rec_view_o), 0);
    init_clr_i = 1'b1; step(); init_clr_i = 1'b0;
    chk("R3 init cleared", int'(init_o), 0);
    chk("R3 still bus_off", int'(bus_off_o), 1);
  endtask

  task automatic t_recover();
    lec_pulses = 0;
    clr_pulses = 0;
    for (int k = 0; k < 10; k++) send_bit(1'b1);
    chk("R6 no code at 10", int'(lec_wr_o), 0);
    send_bit(1'b0);
    chk("R6 view unchanged", int'(rec_view_o), 0);
    for (int k = 0; k < 10; k++) send_bit(1'b1);
    chk("R6 run restarted", int'(lec_wr_o), 0);
    step(); step();
    send_bit(1'b1);
    chk("R5 pulse", int'(lec_wr_o), 1);
    chk("R5 code", int'(lec_code_o), 5);
    chk("R7 view 1", int'(rec_view_o), 1);
    step();
    chk("R5 single cycle", int'(lec_wr_o), 0);
    init_set_i = 1'b1; step(); init_set_i = 1'b0;
    chk("R4 set ignored", int'(init_o), 0);
    init_clr_i = 1'b1; step(); init_clr_i = 1'b0;
    chk("R4 count kept", int'(rec_view_o), 1);
    for (int s = 2; s <= 128; s++) begin
      for (int k = 0; k < 11; k++) send_bit(1'b1);
      lec_pulses += int'(lec_wr_o);
      clr_pulses += int'(cnt_clr_o);
      if (s == 64) begin
        init_set_i = 1'b1; init_clr_i = 1'b1; step();
        init_set_i = 1'b0; init_clr_i = 1'b0;
      end
    end
    chk("R5 codes 2..128", lec_pulses, 127);
    chk("R8 no early clear", clr_pulses, 0);
    chk("R4 not shortened", int'(bus_off_o), 1);
    chk("R7 view wraps 128", int'(rec_view_o), 0);
    for (int k = 0; k < 10; k++) send_bit(1'b1);
    chk("R8 not done before bit", int'(bus_off_o), 1);
    send_bit(1'b1);
    chk("R8 clear", int'(cnt_clr_o), 1);
    chk("R8 code same cycle", int'(lec_wr_o), 1);
    chk("R8 bus_off low", int'(bus_off_o), 0);
    chk("R8 act idle", int'(act_o), 1);
    tec_i = 9'd0; rec_i = 8'd0;
    step();
    chk("R8 clear single", int'(cnt_clr_o), 0);
    chk("R8 stays normal", int'(bus_off_o), 0);
    chk("R8 init low", int'(init_o), 0);
  endtask

  initial begin
    #50000000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_flags();
    t_init_normal();
    t_enter();
    t_hold();
    t_recover();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule